// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Through Word Cache

This block is a small cache placed between one pipeline stage and a slow main memory. Each line holds a single data word. Lines are grouped in sets of two ways, and one replacement bit per set names the way to evict next. The requester sends word-addressed reads and writes. The cache answers each request with one response that carries the data and says whether the tag was present. Toward memory the cache issues a word read when a read misses, and a word write for every store (write-through with write-allocate). The cache size and the read-hit latency are parameters. An instance with a size of 16 and a one-cycle hit suits an instruction port. An instance with a size of 1024 and a four-cycle hit suits a data port.

The request port is valid/ready. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the cache is idle, so one request is in flight at a time. The response is a one-cycle `rsp_valid` pulse with no back-pressure, and the requester must take it. The memory request port is also valid/ready. The cache holds `mem_req_valid` and every request field steady until it sees `mem_req_ready`. Memory answers each request, read or write, with a one-cycle `mem_rsp_valid` pulse.

Top module: `cache2w_top`

## Requirements
- R1: Number of sets = CACHE_SIZE/8. The set index is the low log2(sets) bits of the word address, and the tag is all the remaining upper bits. Two tags in one set, and one tag in several sets, are held at the same time and each returns its own word.
- R2: After reset every line is invalid and every replacement bit is 0. `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and the first read of any address misses.
- R3: A read hit makes no memory request. It returns the stored word with `rsp_hit`=1 and `rsp_write`=0, and `rsp_valid` is high in the HIT_LAT-th cycle after the accepting edge.
- R4: A read miss issues exactly one memory read (`mem_req_write`=0) for the requested address. In the cycle after `mem_rsp_valid`, the cache responds with `mem_rsp_data`, `rsp_hit`=0 and `rsp_write`=0, and the word is installed for later hits.
- R5: A hit in way 0 sets the set's replacement bit to 1, and a hit in way 1 clears it. A miss fills the way the bit names and then inverts the bit.
- R6: A store updates the matching line, or allocates one by the R5 rule. It issues one memory write (`mem_req_write`=1) with the store's address and data. Its response (`rsp_write`=1, `rsp_hit` = tag was present) comes in the cycle after the memory's `mem_rsp_valid`.
- R7: `req_ready` is 0 from the accepting edge until after the response cycle, so requests stall while a hit is timing out or a memory transaction is outstanding.
- R8: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the memory request and all its fields stay unchanged. A `mem_rsp_valid` that arrives when no memory transaction is outstanding is ignored.
- R9: Every accepted request gets exactly one response, and `rsp_valid` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Cache idle, request can transfer |
| req_write | input | 1 | 1 = store, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Tag was present at lookup |
| rsp_write | output | 1 | Response completes a store |
| rsp_data | output | DW | Read data (store data for stores) |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = memory write, 0 = memory read |
| mem_req_addr | output | AW | Memory word address |
| mem_req_wdata | output | DW | Memory write data |
| mem_rsp_valid | input | 1 | Memory read data / write done |
| mem_rsp_data | input | DW | Memory read data |

## Verification
The hardest case to reach from the ports is the replacement order inside one set under a mix of hits and misses. The victim is hidden, so it shows up only when a later access to an evicted tag misses. The bench runs a directed sequence in one set, and then a long pseudo-random mix of reads and stores over a four-set configuration with a small address space. This gives every set many tag conflicts. An arithmetic model of tags and replacement bits, built from the requirements, predicts each hit or miss. The memory model holds off `mem_req_ready` for two cycles on every request, and a stray memory response is driven while the cache is idle.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HITW,
    ST_MREQ,
    ST_MWAIT,
    ST_WREQ,
    ST_WWAIT,
    ST_DONE
  } cstate_e;

  localparam int unsigned NWAYS = 2;
endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
  parameter int unsigned SETS  = 2,
  parameter int unsigned IW    = 1,
  parameter int unsigned TAG_W = 15,
  parameter int unsigned DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [DW-1:0]    rd_data,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [DW-1:0]    wr_data
);
  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q  [SETS];
  logic [DW-1:0]    data_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[idx]  <= wr_tag;
      data_q[idx] <= wr_data;
    end
  end

  assign rd_valid = vld_q[idx];
  assign rd_tag   = tag_q[idx];
  assign rd_data  = data_q[idx];
endmodule

// File: rtl/cache2w_repl.sv
module cache2w_repl #(
  parameter int unsigned SETS = 2,
  parameter int unsigned IW   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] idx,
  input  logic          upd_en,
  input  logic          upd_val,
  output logic          victim
);
  logic [SETS-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (!rst_n) bits_q <= '0;
    else if (upd_en) bits_q[idx] <= upd_val;
  end

  assign victim = bits_q[idx];
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
  import cache2w_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter int unsigned DW      = 32,
  parameter int unsigned HIT_LAT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic          rsp_write,
  output logic [DW-1:0] rsp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  input  logic          hit,
  input  logic          hit_way,
  input  logic          victim,
  input  logic [DW-1:0] hit_data,
  output logic [AW-1:0] cur_addr,
  output logic          line_we,
  output logic          line_way,
  output logic [DW-1:0] line_data,
  output logic          repl_we,
  output logic          repl_val
);
  localparam int unsigned CW = (HIT_LAT > 1) ? $clog2(HIT_LAT) : 1;
  localparam logic [CW-1:0] CNT_INIT = CW'(HIT_LAT - 1);

  cstate_e       state_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] sav_addr_q;
  logic [DW-1:0] sav_data_q;
  logic          sav_hit_q;
  logic          sav_wr_q;
  logic          accept;
  logic          tgt_way;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign tgt_way   = hit ? hit_way : victim;
  assign cur_addr  = (state_q == ST_IDLE) ? req_addr : sav_addr_q;

  always_comb begin
    line_we   = 1'b0;
    line_way  = tgt_way;
    line_data = req_wdata;
    repl_we   = 1'b0;
    repl_val  = ~tgt_way;
    if (accept && req_write) begin
      line_we = 1'b1;
      repl_we = 1'b1;
    end else if (accept && hit) begin
      repl_we = 1'b1;
    end else if (state_q == ST_MWAIT && mem_rsp_valid) begin
      line_we   = 1'b1;
      line_way  = victim;
      line_data = mem_rsp_data;
      repl_we   = 1'b1;
      repl_val  = ~victim;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sav_addr_q <= '0;
      sav_data_q <= '0;
      sav_hit_q  <= 1'b0;
      sav_wr_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            sav_addr_q <= req_addr;
            sav_hit_q  <= hit;
            sav_wr_q   <= req_write;
            if (req_write) begin
              sav_data_q <= req_wdata;
              state_q    <= ST_WREQ;
            end else if (hit) begin
              sav_data_q <= hit_data;
              cnt_q      <= CNT_INIT;
              state_q    <= ST_HITW;
            end else begin
              state_q <= ST_MREQ;
            end
          end
        end
        ST_HITW: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_MREQ:  if (mem_req_ready) state_q <= ST_MWAIT;
        ST_MWAIT: begin
          if (mem_rsp_valid) begin
            sav_data_q <= mem_rsp_data;
            state_q    <= ST_DONE;
          end
        end
        ST_WREQ:  if (mem_req_ready) state_q <= ST_WWAIT;
        ST_WWAIT: if (mem_rsp_valid) state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid     = ((state_q == ST_HITW) && (cnt_q == '0)) || (state_q == ST_DONE);
  assign rsp_hit       = sav_hit_q;
  assign rsp_write     = sav_wr_q;
  assign rsp_data      = sav_data_q;
  assign mem_req_valid = (state_q == ST_MREQ) || (state_q == ST_WREQ);
  assign mem_req_write = (state_q == ST_WREQ);
  assign mem_req_addr  = sav_addr_q;
  assign mem_req_wdata = sav_data_q;
endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
  import cache2w_pkg::*;
#(
  parameter int unsigned CACHE_SIZE = 16,
  parameter int unsigned HIT_LAT    = 1,
  parameter int unsigned AW         = 16,
  parameter int unsigned DW         = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic          rsp_write,
  output logic [DW-1:0] rsp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  localparam int unsigned SETS  = (CACHE_SIZE / 8 > 0) ? CACHE_SIZE / 8 : 1;
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned IW    = (IDX_W > 0) ? IDX_W : 1;
  localparam int unsigned TAG_W = AW - IDX_W;

  logic [AW-1:0]    cur_addr;
  logic [IW-1:0]    lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [NWAYS-1:0] w_valid;
  logic [NWAYS-1:0] w_hit;
  logic [TAG_W-1:0] w_tag  [NWAYS];
  logic [DW-1:0]    w_data [NWAYS];
  logic             hit, hit_way, victim;
  logic [DW-1:0]    hit_data;
  logic             line_we, line_way, repl_we, repl_val;
  logic [DW-1:0]    line_data;

  generate
    if (IDX_W == 0) begin : g_one_set
      assign lk_idx = '0;
    end else begin : g_many_sets
      assign lk_idx = cur_addr[IDX_W-1:0];
    end
  endgenerate
  assign lk_tag = cur_addr[AW-1:IDX_W];

  generate
    for (genvar w = 0; w < NWAYS; w++) begin : g_way
      cache2w_way #(.SETS(SETS), .IW(IW), .TAG_W(TAG_W), .DW(DW)) way_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (lk_idx),
        .rd_valid (w_valid[w]),
        .rd_tag   (w_tag[w]),
        .rd_data  (w_data[w]),
        .wr_en    (line_we && (line_way == w[0])),
        .wr_tag   (lk_tag),
        .wr_data  (line_data)
      );
      assign w_hit[w] = w_valid[w] && (w_tag[w] == lk_tag);
    end
  endgenerate

  assign hit      = |w_hit;
  assign hit_way  = w_hit[1];
  assign hit_data = w_hit[1] ? w_data[1] : w_data[0];

  cache2w_repl #(.SETS(SETS), .IW(IW)) repl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx     (lk_idx),
    .upd_en  (repl_we),
    .upd_val (repl_val),
    .victim  (victim)
  );

  cache2w_ctrl #(.AW(AW), .DW(DW), .HIT_LAT(HIT_LAT)) ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_write     (rsp_write),
    .rsp_data      (rsp_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .hit           (hit),
    .hit_way       (hit_way),
    .victim        (victim),
    .hit_data      (hit_data),
    .cur_addr      (cur_addr),
    .line_we       (line_we),
    .line_way      (line_way),
    .line_data     (line_data),
    .repl_we       (repl_we),
    .repl_val      (repl_val)
  );
endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic          rsp_write,
  input logic [DW-1:0] rsp_data,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [AW-1:0] mem_req_addr,
  input logic [DW-1:0] mem_req_wdata,
  input logic          mem_rsp_valid,
  input logic [DW-1:0] mem_rsp_data
);
  // R7
  stall_on_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8
  memreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata)));

  // R6
  write_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> (mem_req_valid && mem_req_write
      && mem_req_addr == $past(req_addr) && mem_req_wdata == $past(req_wdata)));

  // R4
  miss_fill_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit && !rsp_write) |-> ($past(mem_rsp_valid)
      && rsp_data == $past(mem_rsp_data)));
endmodule

bind cache2w_top cache2w_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_write     (req_write),
  .req_addr      (req_addr),
  .req_wdata     (req_wdata),
  .rsp_valid     (rsp_valid),
  .rsp_hit       (rsp_hit),
  .rsp_write     (rsp_write),
  .rsp_data      (rsp_data),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_data  (mem_rsp_data)
);

// File: tb/cache2w_tb_top.sv
module cache2w_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CSIZE      = 32;
  localparam int HLAT       = 3;
  localparam int AW         = 6;
  localparam int DW         = 32;
  localparam int NSETS      = CSIZE / 8;
  localparam int NADDR      = 1 << AW;
  localparam int MLAT       = 3;
  localparam int WDOG       = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, rsp_hit, rsp_write;
  logic [DW-1:0] rsp_data;
  logic          mem_req_valid, mem_req_write;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;

  int n_tests = 0;
  int n_fail  = 0;

  logic [DW-1:0] bmem [NADDR];
  bit            mv [NSETS][2];
  int            mt [NSETS][2];
  bit            mr [NSETS];

  always #(CLK_PERIOD / 2) clk = ~clk;

  cache2w_top #(.CACHE_SIZE(CSIZE), .HIT_LAT(HLAT), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_write(rsp_write), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference from R1/R5: set = addr % sets, tag = addr / sets.
  function automatic bit model_upd(input int a);
    int s = a % NSETS;
    int t = a / NSETS;
    int v;
    if (mv[s][0] && mt[s][0] == t) begin mr[s] = 1'b1; return 1'b1; end
    if (mv[s][1] && mt[s][1] == t) begin mr[s] = 1'b0; return 1'b1; end
    v = int'(mr[s]);
    mv[s][v] = 1'b1;
    mt[s][v] = t;
    mr[s] = ~mr[s];
    return 1'b0;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_acc(input bit wr, input int a, input logic [DW-1:0] d, input string htag);
    bit exp_hit, got, ready_bad, hold_bad;
    logic [DW-1:0] exp_d, r_data, md;
    bit r_hit, r_wr, mw;
    logic [AW-1:0] ma;
    int cyc, nmem;
    exp_hit = model_upd(a);
    if (wr) bmem[a] = d;
    exp_d = bmem[a];
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    chk(req_ready === 1'b1, "R7", "ready when idle", {31'b0, req_ready}, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1; got = 0; nmem = 0; ready_bad = 0; hold_bad = 0;
    ma = '0; mw = 0; md = '0; r_hit = 0; r_wr = 0; r_data = '0;
    while (!got && cyc < 400) begin
      if (req_ready) ready_bad = 1;
      if (rsp_valid) begin
        got = 1; r_hit = rsp_hit; r_wr = rsp_write; r_data = rsp_data;
      end else if (mem_req_valid) begin
        nmem++;
        ma = mem_req_addr; mw = mem_req_write; md = mem_req_wdata;
        repeat (2) begin
          step(); cyc++;
          if (!mem_req_valid || mem_req_addr !== ma || mem_req_write !== mw ||
              mem_req_wdata !== md || req_ready) hold_bad = 1;
        end
        mem_req_ready = 1'b1;
        step(); cyc++;
        mem_req_ready = 1'b0;
        repeat (MLAT) begin
          if (req_ready || rsp_valid) ready_bad = 1;
          step(); cyc++;
        end
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mw ? 32'hDEAD_BEEF : bmem[ma];
        step(); cyc++;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
      end else begin
        step(); cyc++;
      end
    end
    chk(got, "R9", "response arrived", 32'(got), 1);
    chk(r_wr == wr, "R6", "rsp_write", 32'(r_wr), 32'(wr));
    chk(r_hit == exp_hit, htag, $sformatf("hit flag addr %0d", a), 32'(r_hit), 32'(exp_hit));
    chk(nmem == ((wr || !exp_hit) ? 1 : 0), wr ? "R6" : (exp_hit ? "R3" : "R4"),
        "memory request count", 32'(nmem), (wr || !exp_hit) ? 1 : 0);
    chk(!ready_bad, "R7", "ready low while busy", 32'(ready_bad), 0);
    chk(!hold_bad, "R8", "memory request held", 32'(hold_bad), 0);
    if (!wr) chk(r_data === exp_d, exp_hit ? "R3" : "R4", $sformatf("read data addr %0d", a), r_data, exp_d);
    if (!wr && exp_hit) chk(cyc == HLAT, "R3", "hit latency", 32'(cyc), HLAT);
    if (nmem == 1) begin
      chk(ma == AW'(a), wr ? "R6" : "R4", "memory address", 32'(ma), 32'(a));
      chk(mw == wr, wr ? "R6" : "R4", "memory write flag", 32'(mw), 32'(wr));
      if (wr) chk(md === d, "R6", "memory write data", md, d);
    end
    step();
    chk(rsp_valid == 1'b0, "R9", "single-cycle response", 32'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R7", "ready after response", 32'(req_ready), 1);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WDOG, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < NADDR; i++) bmem[i] = (32'(i) * 32'h0101_0101) ^ 32'hC0DE_0000;
    for (int s = 0; s < NSETS; s++) begin
      mv[s][0] = 0; mv[s][1] = 0; mt[s][0] = 0; mt[s][1] = 0; mr[s] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk(req_ready == 1'b1, "R2", "ready after reset", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R2", "no response after reset", 32'(rsp_valid), 0);
    chk(mem_req_valid == 1'b0, "R2", "no memory request after reset", 32'(mem_req_valid), 0);

    // R5 directed replacement order in set 1 (tags 0,1,2)
    do_acc(0, 1, '0, "R2");
    do_acc(0, 5, '0, "R5");
    do_acc(0, 1, '0, "R5");
    do_acc(0, 9, '0, "R5");
    do_acc(0, 5, '0, "R5");
    do_acc(0, 1, '0, "R5");
    do_acc(0, 9, '0, "R5");

    // R2 first touch of every other address misses
    for (int a = 0; a < NADDR; a++)
      if (a % NSETS != 1) do_acc(0, a, '0, "R2");

    // R1 two tags in one set plus the same tag across sets
    do_acc(1, 2, 32'h1111_0002, "R1");
    do_acc(1, 6, 32'h1111_0006, "R1");
    do_acc(1, 3, 32'h1111_0003, "R1");
    do_acc(0, 2, '0, "R1");
    do_acc(0, 6, '0, "R1");
    do_acc(0, 3, '0, "R1");

    // R6 store hit then store miss then read back
    do_acc(1, 6, 32'h2222_0006, "R6");
    do_acc(1, 10, 32'h2222_000A, "R6");
    do_acc(0, 10, '0, "R6");

    // R8 stray memory response while idle is ignored
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_data = 32'hBAD0_BAD0;
    step();
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    chk(rsp_valid == 1'b0, "R8", "no response to stray memory pulse", 32'(rsp_valid), 0);
    chk(mem_req_valid == 1'b0, "R8", "no request after stray pulse", 32'(mem_req_valid), 0);
    do_acc(0, 10, '0, "R8");
    do_acc(0, 6, '0, "R8");

    // Mixed pseudo-random sweep, R5 replacement predicted by model
    lfsr = 16'hACE1;
    for (int k = 0; k < 700; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_acc(lfsr[8:7] == 2'b00, int'(lfsr[5:0]) % NADDR,
             {lfsr, 16'(k)}, "R5");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule